// File: doc/BRIEF.md
# Dual-Replica Lockstep Datapath with Checkpoint Rollback

This block runs two copies of a small register-file datapath side by side. Both copies receive the same operation stream, and their result outputs are compared on every cycle. A disagreement shows that one copy has gone wrong, but it does not show which copy. For this reason the block does not try to pick a winner. It reloads both copies from a saved context that is known to be good and asks the producer to send the affected operations again.

A context store sits outside the replicas and holds one snapshot of the architectural registers. A snapshot is taken after every `CKPT_N` accepted operations, and only when the outputs agreed all the way up to that point. After a disagreement, the block holds off new input for a fixed recovery window, drives an error flag, and copies the snapshot back into both replicas. If no snapshot has been taken yet, the context store still holds its reset value, which is all zeros. A saturating counter reports how many recoveries have happened.

Each operation names a register and carries an operand. The operation updates that register, and the new register value is returned as the result. The input `upset_i` models a single-event upset in the second replica. It lets a fault be placed on one chosen operation.

Top module: `lockstep_rollback`

## Requirements
- R1: After synchronous reset, `in_ready`=1, `res_valid`=0, `err_o`=0 and `rb_count`=0, and all registers in both replicas read as zero.
- R2: An operation accepted at a clock edge (`in_valid`&`in_ready`) produces `res_valid`=1 in the cycle that follows, with `res_data` equal to the new value of register `in_idx`. The `in_op` encoding is: 0 loads the operand, 1 adds the operand, 2 XORs with the operand, 3 ANDs with the operand.
- R3: Count the accepted operations since the last snapshot or recovery. In the cycle after the `CKPT_N`-th one, `in_ready` is 0 while the context is saved. It returns to 1 in the next cycle.
- R4: In a cycle where the two replicas' outputs differ, `res_valid` is 0 and `in_ready` is 0.
- R5: After a recovery, both replicas hold the most recently saved context. Operations accepted after that snapshot are lost and must be sent again.
- R6: Recovery starts one cycle after the mismatch. `err_o` is 1 and `in_ready` is 0 for exactly `ROLL_CYC` cycles. In the cycle after those, `err_o` returns to 0 and `in_ready` returns to 1.
- R7: A mismatch before any snapshot has been taken restores the all-zero reset state.
- R8: No snapshot is taken if the mismatch appears in the checkpoint cycle. Recovery then restores the earlier snapshot.
- R9: `rb_count` increments by one on each recovery and saturates at 2^`RB_W`-1.
- R10: `upset_i` flips bit 0 of the value that the second replica writes, and only for an operation accepted in that cycle. When no operation is accepted, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 2 | Operation code |
| in_idx | input | $clog2(NREG) | Target register |
| in_data | input | DATA_W | Operand |
| upset_i | input | 1 | Fault injection into the second replica for the accepted operation |
| res_valid | output | 1 | Result valid, both replicas agreeing |
| res_data | output | DATA_W | New register value |
| err_o | output | 1 | Recovery in progress |
| rb_count | output | RB_W | Saturating recovery count |

## Verification
A corrupted replica becomes visible one cycle after the bad write: `res_valid` drops, `err_o` rises in the following cycle, and `rb_count` steps. Corruption of the context store is different, because it stays hidden until the next recovery. The bench therefore reads registers back with add-zero operations right after directed recoveries, both before the first snapshot and after a skipped snapshot. It also checks that the readback matches the snapshot model the bench keeps for itself. If the snapshot counter is wrong, `in_ready` drops in the wrong cycle after the `CKPT_N`-th acceptance.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_ADD  = 2'd1,
        OP_XOR  = 2'd2,
        OP_AND  = 2'd3
    } op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_ROLL = 1'b1
    } ctl_e;

    // Register update; callers truncate to their own data width.
    function automatic logic [63:0] lsr_alu(op_e op, logic [63:0] cur, logic [63:0] opnd);
        logic [63:0] r;
        case (op)
            OP_LOAD: r = opnd;
            OP_ADD:  r = cur + opnd;
            OP_XOR:  r = cur ^ opnd;
            default: r = cur & opnd;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsr_replica.sv
module lsr_replica
    import lsr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 4,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           issue,
    input  op_e                            op,
    input  logic [IDX_W-1:0]               idx,
    input  logic [DATA_W-1:0]              opnd,
    input  logic                           upset,
    input  logic                           restore,
    input  logic [NREG-1:0][DATA_W-1:0]    restore_ctx,
    output logic [NREG-1:0][DATA_W-1:0]    ctx,
    output logic                           res_valid,
    output logic [DATA_W-1:0]              res_data
);

    logic [NREG-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]           next_val;

    always_comb begin
        next_val = DATA_W'(lsr_alu(op, 64'(regs_q[idx]), 64'(opnd)));
        next_val[0] = next_val[0] ^ upset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q    <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else if (restore) begin
            regs_q    <= restore_ctx;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else if (issue) begin
            regs_q[idx] <= next_val;
            res_valid   <= 1'b1;
            res_data    <= next_val;
        end else begin
            res_valid <= 1'b0;
        end
    end

    assign ctx = regs_q;

    AST_RESTORE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restore |=> (!res_valid && regs_q == $past(restore_ctx))) else $error("restore"); // R5

endmodule

// File: rtl/lsr_context.sv
module lsr_context #(
    parameter int DATA_W = 16,
    parameter int NREG   = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        save,
    input  logic [NREG-1:0][DATA_W-1:0] ctx_in,
    output logic [NREG-1:0][DATA_W-1:0] ctx_out
);

    logic [NREG-1:0][DATA_W-1:0] shadow_q;

    // Reset value equals the replicas' reset state, so an early restore
    // returns both copies to zero.
    always_ff @(posedge clk) begin
        if (rst)       shadow_q <= '0;
        else if (save) shadow_q <= ctx_in;
    end

    assign ctx_out = shadow_q;

    AST_SAVE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        save |=> ctx_out == $past(ctx_in)) else $error("save"); // R3
    AST_HOLD_NO_SAVE: assert property (@(posedge clk) disable iff (rst)
        !save |=> $stable(ctx_out)) else $error("hold"); // R8

endmodule

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
    import lsr_pkg::*;
#(
    parameter int CKPT_N   = 4,
    parameter int ROLL_CYC = 3,
    parameter int RB_W     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            mismatch,
    output logic            in_ready,
    output logic            issue,
    output logic            save,
    output logic            restore,
    output logic            err,
    output logic [RB_W-1:0] rb_count
);

    localparam int CNT_W = $clog2(CKPT_N + 1);
    localparam int TMR_W = (ROLL_CYC > 1) ? $clog2(ROLL_CYC) : 1;
    localparam logic [CNT_W-1:0] CKPT_LIM = CNT_W'(CKPT_N);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(ROLL_CYC - 1);
    localparam logic [RB_W-1:0]  RB_MAX   = {RB_W{1'b1}};

    ctl_e             state_q;
    logic [CNT_W-1:0] acc_q;
    logic [TMR_W-1:0] tmr_q;
    logic [RB_W-1:0]  rb_q;
    logic             run, at_ckpt;

    assign run      = (state_q == ST_RUN);
    assign at_ckpt  = (acc_q == CKPT_LIM);
    assign in_ready = run && !mismatch && !at_ckpt;
    assign issue    = in_ready && in_valid;
    assign save     = run && at_ckpt && !mismatch;
    assign restore  = run && mismatch;
    assign err      = !run;
    assign rb_count = rb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            acc_q   <= '0;
            tmr_q   <= '0;
            rb_q    <= '0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (mismatch) begin
                        state_q <= ST_ROLL;
                        tmr_q   <= TMR_LOAD;
                        acc_q   <= '0;
                        if (rb_q != RB_MAX) rb_q <= rb_q + 1'b1;
                    end else if (save) begin
                        acc_q <= '0;
                    end else if (issue) begin
                        acc_q <= acc_q + 1'b1;
                    end
                end
                default: begin
                    if (tmr_q == '0) state_q <= ST_RUN;
                    else             tmr_q   <= tmr_q - 1'b1;
                end
            endcase
        end
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
        acc_q <= CKPT_LIM) else $error("acc"); // R3
    AST_RB_MONO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rb_q >= $past(rb_q)) else $error("rb"); // R9
    AST_ROLL_ENTRY: assert property (@(posedge clk) disable iff (rst)
        restore |=> (err && !in_ready)) else $error("entry"); // R6
    AST_TMR_RANGE: assert property (@(posedge clk) disable iff (rst)
        !run |-> tmr_q <= TMR_LOAD) else $error("tmr"); // R6

endmodule

// File: rtl/lockstep_rollback.sv
module lockstep_rollback
    import lsr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NREG     = 4,
    parameter int CKPT_N   = 4,
    parameter int ROLL_CYC = 3,
    parameter int RB_W     = 4,
    localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_data,
    input  logic              upset_i,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              err_o,
    output logic [RB_W-1:0]   rb_count
);

    localparam int NREP = 2;

    logic [NREG-1:0][DATA_W-1:0] rep_ctx [NREP];
    logic                        rep_v   [NREP];
    logic [DATA_W-1:0]           rep_d   [NREP];
    logic [NREG-1:0][DATA_W-1:0] ckpt_ctx;
    logic issue, save, restore, mismatch;

    for (genvar g = 0; g < NREP; g++) begin : g_rep
        lsr_replica #(.DATA_W(DATA_W), .NREG(NREG)) u_rep (
            .clk         (clk),
            .rst         (rst),
            .issue       (issue),
            .op          (op_e'(in_op)),
            .idx         (in_idx),
            .opnd        (in_data),
            .upset       ((g == NREP - 1) ? (upset_i && issue) : 1'b0),
            .restore     (restore),
            .restore_ctx (ckpt_ctx),
            .ctx         (rep_ctx[g]),
            .res_valid   (rep_v[g]),
            .res_data    (rep_d[g])
        );
    end

    assign mismatch = (rep_v[0] != rep_v[1]) ||
                      (rep_v[0] && (rep_d[0] != rep_d[1]));

    lsr_context #(.DATA_W(DATA_W), .NREG(NREG)) u_ctx (
        .clk     (clk),
        .rst     (rst),
        .save    (save),
        .ctx_in  (rep_ctx[0]),
        .ctx_out (ckpt_ctx)
    );

    lsr_ctrl #(.CKPT_N(CKPT_N), .ROLL_CYC(ROLL_CYC), .RB_W(RB_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .mismatch (mismatch),
        .in_ready (in_ready),
        .issue    (issue),
        .save     (save),
        .restore  (restore),
        .err      (err_o),
        .rb_count (rb_count)
    );

    assign res_valid = rep_v[0] && !mismatch;
    assign res_data  = rep_d[0];

    AST_RESTORE_EQUAL: assert property (@(posedge clk) disable iff (rst)
        restore |=> rep_ctx[0] == rep_ctx[1]) else $error("eq"); // R5
    AST_ERR_NOREADY: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !in_ready) else $error("rdy"); // R6
    AST_CKPT_AGREE: assert property (@(posedge clk) disable iff (rst)
        save |-> rep_ctx[0] == rep_ctx[1]) else $error("ckpt"); // R8

endmodule

// File: tb/sim_lockstep_rollback.sv
module sim_lockstep_rollback;
    localparam int DATA_W = 16, NREG = 4, CKPT_N = 4, ROLL_CYC = 3, RB_W = 4;
    localparam int IDX_W = 2;
    localparam int QMAX = CKPT_N + 2;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_ready, upset_i = 0;
    logic [1:0] in_op = 0;
    logic [IDX_W-1:0] in_idx = 0;
    logic [DATA_W-1:0] in_data = 0, res_data;
    logic res_valid, err_o;
    logic [RB_W-1:0] rb_count;

    always #2.5 clk = ~clk;

    lockstep_rollback #(.DATA_W(DATA_W), .NREG(NREG), .CKPT_N(CKPT_N),
        .ROLL_CYC(ROLL_CYC), .RB_W(RB_W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_idx(in_idx), .in_data(in_data), .upset_i(upset_i),
        .res_valid(res_valid), .res_data(res_data), .err_o(err_o), .rb_count(rb_count));

    int nchk = 0, nfail = 0, cyc = 0;
    logic [DATA_W-1:0] ref_r [NREG];
    logic [DATA_W-1:0] ref_sh [NREG];
    int acc_cnt = 0;
    int exp_rb = 0;
    bit replay_en = 1;
    logic [1:0] lg_op [QMAX];
    logic [IDX_W-1:0] lg_idx [QMAX];
    logic [DATA_W-1:0] lg_dat [QMAX];
    int lg_n = 0;

    function automatic logic [DATA_W-1:0] model(logic [1:0] op, logic [DATA_W-1:0] cur, logic [DATA_W-1:0] d);
        case (op)
            2'd0: return d;
            2'd1: return cur + d;
            2'd2: return cur ^ d;
            default: return cur & d;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    // One operation; returns rolled=1 if a recovery followed.
    task automatic issue_one(logic [1:0] op, logic [IDX_W-1:0] idx, logic [DATA_W-1:0] d,
                             bit up, string tag, output bit rolled);
        bit got;
        logic [DATA_W-1:0] ev;
        rolled = 0;
        in_valid = 1; in_op = op; in_idx = idx; in_data = d; upset_i = up;
        got = 0;
        while (!got) begin
            #1 got = in_ready;
            @(posedge clk); @(negedge clk);
        end
        in_valid = 0; upset_i = 0;
        ev = model(op, ref_r[idx], d);
        lg_op[lg_n] = op; lg_idx[lg_n] = idx; lg_dat[lg_n] = d; lg_n++;
        if (!up) begin
            chk(res_valid == 1 && res_data == ev, {tag, " result (R2)"}, res_data, ev);
            ref_r[idx] = ev;
            acc_cnt++;
            if (acc_cnt == CKPT_N) begin
                chk(in_ready == 0, "R3 ready low in checkpoint cycle", in_ready, 0);
                @(negedge clk);
                chk(in_ready == 1 && err_o == 0, "R3 ready back after checkpoint", in_ready, 1);
                for (int i = 0; i < NREG; i++) ref_sh[i] = ref_r[i];
                acc_cnt = 0; lg_n = 0;
            end
        end else begin
            chk(res_valid == 0 && in_ready == 0 && err_o == 0, "R4 mismatch masks output",
                {res_valid, in_ready, err_o}, 0);
            if (exp_rb < (1 << RB_W) - 1) exp_rb++;
            for (int i = 0; i < ROLL_CYC; i++) begin
                @(negedge clk);
                chk(err_o == 1 && in_ready == 0, "R6 recovery window", {err_o, in_ready}, 2);
                if (i == 0) chk(rb_count == exp_rb, "R9 rollback count", rb_count, exp_rb);
            end
            @(negedge clk);
            chk(err_o == 0 && in_ready == 1, "R6 recovery end", {err_o, in_ready}, 1);
            for (int i = 0; i < NREG; i++) ref_r[i] = ref_sh[i];
            acc_cnt = 0;
            rolled = 1;
        end
    endtask

    task automatic send(logic [1:0] op, logic [IDX_W-1:0] idx, logic [DATA_W-1:0] d,
                        bit up, string tag);
        logic [1:0] q_op [QMAX];
        logic [IDX_W-1:0] q_idx [QMAX];
        logic [DATA_W-1:0] q_dat [QMAX];
        bit q_up [QMAX];
        int qn = 1, head = 0;
        bit rolled;
        q_op[0] = op; q_idx[0] = idx; q_dat[0] = d; q_up[0] = up;
        while (head < qn) begin
            issue_one(q_op[head], q_idx[head], q_dat[head], q_up[head], tag, rolled);
            head++;
            if (rolled) begin
                if (replay_en) begin
                    qn = 0; head = 0;
                    for (int i = 0; i < lg_n; i++) begin
                        q_op[qn] = lg_op[i]; q_idx[qn] = lg_idx[i];
                        q_dat[qn] = lg_dat[i]; q_up[qn] = 0; qn++;
                    end
                end
                lg_n = 0;
            end
        end
    endtask

    task automatic align_ckpt();
        while (acc_cnt != 0) send(2'd1, 0, 0, 0, "pad");
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NREG; i++) begin ref_r[i] = 0; ref_sh[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(in_ready == 1 && res_valid == 0 && err_o == 0 && rb_count == 0, "R1 reset outputs",
            {in_ready, res_valid, err_o, rb_count}, 32'h40);
        send(2'd1, 3, 0, 0, "R1 reset register readback");

        // R7: fault before any checkpoint restores zero state
        replay_en = 0;
        send(2'd0, 1, 16'h0005, 0, "R7 load");
        send(2'd0, 2, 16'h0007, 1, "R7 upset");
        send(2'd1, 1, 0, 0, "R7 reg1 zero after early restore");
        send(2'd1, 2, 0, 0, "R7 reg2 zero after early restore");

        // R8: fault on the checkpoint-completing op keeps the older snapshot
        align_ckpt();
        for (int i = 0; i < NREG; i++) send(2'd0, IDX_W'(i), DATA_W'(16'h1000 + i), 0, "R8 setup");
        send(2'd0, 0, 16'h0011, 0, "R8 a");
        send(2'd0, 1, 16'h0022, 0, "R8 b");
        send(2'd0, 2, 16'h0033, 0, "R8 c");
        send(2'd0, 3, 16'h0044, 1, "R8 upset on Nth");
        send(2'd1, 0, 0, 0, "R8 reg0 holds older snapshot");
        send(2'd1, 3, 0, 0, "R8 reg3 holds older snapshot");

        // R10: upset with no accepted operation has no effect
        align_ckpt();
        upset_i = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(err_o == 0 && in_ready == 1, "R10 idle upset ignored", {err_o, in_ready}, 1);
        end
        upset_i = 0;
        send(2'd1, 0, 0, 0, "R10 reg0 intact");

        // R9: saturation
        for (int i = 0; i < 18; i++) send(2'd2, 1, 16'h00F0, 1, "R9 upset");
        chk(rb_count == (1 << RB_W) - 1, "R9 saturated", rb_count, (1 << RB_W) - 1);

        // R5 / R2: random stream with replay
        replay_en = 1;
        for (int n = 0; n < 400; n++) begin
            logic [1:0] op = 2'($urandom_range(0, 3));
            logic [IDX_W-1:0] ix = IDX_W'($urandom_range(0, NREG - 1));
            logic [DATA_W-1:0] dv = DATA_W'($urandom());
            bit up = ($urandom_range(0, 11) == 0);
            send(op, ix, dv, up, "R5 random");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        for (int i = 0; i < NREG; i++) send(2'd1, IDX_W'(i), 0, 0, "R5 final readback");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule